// File: doc/BRIEF.md
# Serial PHY Lane Control and Status Register File

This block is the software-visible control and status window of a four-lane serial PHY. A processor reaches it over a 32-bit memory-mapped slave port with a 9-bit word address, separate read and write strobes and a wait output. Through it, software drives the per-lane reset requests that go to the reset sequencer and the transceiver, the serial loopback enables and the clock-recovery lock-mode requests. It also reads back the clock-recovery lock indications and the reset sequencer's ready flags.

Resets come in two kinds, and a per-channel enable mask gates both. A command register fires a one-cycle request to the reset sequencer and keeps no state. A manual register holds reset levels until software writes them back to zero. Lane synchronisation events, code-group violations and disparity errors are collected in sticky capture registers. A read returns their contents and clears them. A disparity error is always counted as a code error as well. One further register bit gives the simulation environment a flag for shortened timers.

Top module: `serdes_csr`

## Requirements
- R1: Outside a read, `bus_wait` is low, so writes complete in the cycle they are presented. A read raises `bus_wait` for exactly its first cycle. `bus_rdata` holds the registered result in the following cycle, when `bus_wait` is low.
- R2: The channel enable mask at word 0x041 resets to ones in bits [3:0], one bit per channel, and is read-write. Bits [31:4] read as zero.
- R3: Writing word 0x042 with bit 0 set drives `tx_rst_pulse` to the mask value for exactly the one cycle after the write. Bit 1 does the same on `rx_rst_pulse`. The outputs are zero otherwise. A read of word 0x042 returns `seq_tx_ready` in bit 0 and `seq_rx_ready` in bit 1, with all other bits zero.
- R4: Word 0x044 holds three reset levels: bit 1 drives `tx_rst_hold`, bit 2 drives `rx_ana_rst_hold` and bit 3 drives `rx_rst_hold`. Each output equals its level ANDed with the mask. A level stays until software writes 0 to it. Bits 0 and [31:4] read as zero.
- R5: Words 0x061 (`loopback_en`), 0x064 (`cdr_ltd_req`) and 0x065 (`cdr_ltr_req`) are read-write, with bit n controlling channel n. They reset to zero, and bits [31:4] read as zero.
- R6: Words 0x066 and 0x067 return `cdr_on_data` and `cdr_on_ref` in bits [3:0]. Writes to them change nothing.
- R7: Word 0x084 bit n captures any `lane_sync_evt[n]` pulse. A read returns the captured bits and clears them.
- R8: Word 0x085 returns the code-error capture in bits [15:8] and the disparity capture in bits [7:0]. Event bit k of `lane_code_evt`/`lane_disp_evt` (lane k/2) maps to bit 8+k and bit k respectively. Both fields are sticky, and one read clears both.
- R9: A `lane_disp_evt[k]` pulse sets both disparity bit k and code-error bit 8+k.
- R10: An event that arrives in the same cycle as the clearing read stays captured afterwards. The read that clears does not return it.
- R11: Word 0x08a bit 0 is a read-write flag driving `fast_sim`, reset to zero.
- R12: Reads of any other address return zero. Writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_rdata | output | 32 | Registered read data |
| bus_wait | output | 1 | Slave stall; the master holds its controls while high |
| seq_tx_ready | input | 1 | Reset sequencer transmit-ready flag |
| seq_rx_ready | input | 1 | Reset sequencer receive-ready flag |
| cdr_on_data | input | 4 | Per-channel clock recovery locked to data |
| cdr_on_ref | input | 4 | Per-channel clock recovery locked to reference |
| lane_sync_evt | input | 4 | Per-lane synchronisation event pulses |
| lane_code_evt | input | 8 | Code-group violation pulses, two per lane |
| lane_disp_evt | input | 8 | Disparity error pulses, two per lane |
| tx_rst_pulse | output | 4 | One-cycle masked transmit digital reset request |
| rx_rst_pulse | output | 4 | One-cycle masked receive digital reset request |
| tx_rst_hold | output | 4 | Held masked transmit digital reset |
| rx_ana_rst_hold | output | 4 | Held masked receive analog reset |
| rx_rst_hold | output | 4 | Held masked receive digital reset |
| loopback_en | output | 4 | Per-channel serial loopback enable |
| cdr_ltd_req | output | 4 | Per-channel lock-to-data request |
| cdr_ltr_req | output | 4 | Per-channel lock-to-reference request |
| fast_sim | output | 1 | Shortened-timer flag for simulation |

## Verification
The assertions check the following on every cycle:
- the one-cycle wait shape of reads;
- that every reset pulse has a command write one cycle earlier and stays inside the previous mask;
- that held resets move only on mask or manual-register writes;
- that sync capture bits stay set unless a clearing read occurs;
- that a disparity event always lands in the code-error field;
- that any sync event, including one that meets a clearing read, is captured;
- that the simulation flag stays stable.

Only the bench's scenarios can show several other behaviours:
- the exact read-back values, including the field positions of the error register;
- that one read clears both error fields;
- that a read does not return an event arriving in its own clearing cycle;
- that unmapped addresses and the read-only lock words leave every register untouched.

// File: rtl/serdes_csr_pkg.sv
// Shared definitions for the serial PHY control/status register file.
// Holds the word map, the register selector type and the decode function.
// Assumes a 9-bit word address and a 32-bit data path.
package serdes_csr_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    // Word offsets that software depends on.
    localparam logic [ADDR_W-1:0] A_CHMASK = 9'h041;
    localparam logic [ADDR_W-1:0] A_RSTCMD = 9'h042;
    localparam logic [ADDR_W-1:0] A_RSTMAN = 9'h044;
    localparam logic [ADDR_W-1:0] A_LOOP   = 9'h061;
    localparam logic [ADDR_W-1:0] A_LTDREQ = 9'h064;
    localparam logic [ADDR_W-1:0] A_LTRREQ = 9'h065;
    localparam logic [ADDR_W-1:0] A_LTDST  = 9'h066;
    localparam logic [ADDR_W-1:0] A_LTRST  = 9'h067;
    localparam logic [ADDR_W-1:0] A_SYNC   = 9'h084;
    localparam logic [ADDR_W-1:0] A_ERR    = 9'h085;
    localparam logic [ADDR_W-1:0] A_SIM    = 9'h08a;

    // Bit positions inside the manual reset word and the error word.
    localparam int MAN_LSB      = 1;
    localparam int MAN_W        = 3;
    localparam int ERR_CODE_LSB = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CHMASK,
        SEL_RSTCMD,
        SEL_RSTMAN,
        SEL_LOOP,
        SEL_LTDREQ,
        SEL_LTRREQ,
        SEL_LTDST,
        SEL_LTRST,
        SEL_SYNC,
        SEL_ERR,
        SEL_SIM
    } reg_sel_e;

    // Map a word address to the register it selects.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_CHMASK: decode_addr = SEL_CHMASK;
            A_RSTCMD: decode_addr = SEL_RSTCMD;
            A_RSTMAN: decode_addr = SEL_RSTMAN;
            A_LOOP:   decode_addr = SEL_LOOP;
            A_LTDREQ: decode_addr = SEL_LTDREQ;
            A_LTRREQ: decode_addr = SEL_LTRREQ;
            A_LTDST:  decode_addr = SEL_LTDST;
            A_LTRST:  decode_addr = SEL_LTRST;
            A_SYNC:   decode_addr = SEL_SYNC;
            A_ERR:    decode_addr = SEL_ERR;
            A_SIM:    decode_addr = SEL_SIM;
            default:  decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/serdes_csr_port.sv
// Slave port front end: decodes the address and shapes the handshake.
// A read stalls the master for exactly one cycle so that read data can be
// registered. A write completes in the cycle it is presented.
// Assumes the master holds its controls steady while bus_wait is high.
module serdes_csr_port
    import serdes_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic              rd_cap,
    output logic              bus_wait
);

    logic rd_pend;

    // Marks the second cycle of a read, in which the data is already registered.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_pend <= 1'b0;
        else        rd_pend <= bus_rd && !rd_pend;
    end

    assign rd_cap   = bus_rd && !rd_pend;
    assign bus_wait = rd_cap;
    assign wr_stb   = bus_wr;
    assign sel      = decode_addr(bus_addr);

endmodule

// File: rtl/serdes_csr_sticky.sv
// Bank of sticky event capture bits with clear-on-read.
// An event raised in the clearing cycle wins over the clear, so no event is lost.
// Assumes event inputs are synchronous to clk.
module serdes_csr_sticky #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr,
    output logic [WIDTH-1:0] q
);

    // Accumulate events. The clear applies to old content only.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~{WIDTH{clr}}) | evt;
    end

endmodule

// File: rtl/serdes_csr_rstctl.sv
// Per-channel reset request logic.
// Command writes fire one-cycle requests. The manual word keeps three held
// levels. The channel enable mask gates every output.
// Pulses use the mask as it was at the command write. Held levels follow the
// live mask.
module serdes_csr_rstctl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] mask,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_data,
    input  logic              man_wr,
    input  logic [2:0]        man_data,
    output logic [2:0]        man_q,
    output logic [NUM_CH-1:0] tx_pulse,
    output logic [NUM_CH-1:0] rx_pulse,
    output logic [NUM_CH-1:0] tx_hold,
    output logic [NUM_CH-1:0] rxa_hold,
    output logic [NUM_CH-1:0] rxd_hold
);

    // One-cycle masked requests, cleared on every cycle without a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pulse <= '0;
            rx_pulse <= '0;
        end else if (cmd_wr) begin
            tx_pulse <= mask & {NUM_CH{cmd_data[0]}};
            rx_pulse <= mask & {NUM_CH{cmd_data[1]}};
        end else begin
            tx_pulse <= '0;
            rx_pulse <= '0;
        end
    end

    // Held levels: {rx digital, rx analog, tx digital}.
    always_ff @(posedge clk) begin
        if (!rst_n)      man_q <= '0;
        else if (man_wr) man_q <= man_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Gate each held level by this channel's enable bit.
        assign tx_hold[c]  = man_q[0] & mask[c];
        assign rxa_hold[c] = man_q[1] & mask[c];
        assign rxd_hold[c] = man_q[2] & mask[c];
    end

endmodule

// File: rtl/serdes_csr.sv
// Control/status register file for a multi-lane serial PHY.
// - Holds the channel mask, the loopback enables, the lock-mode requests and
//   the simulation flag.
// - Routes the reset controls through serdes_csr_rstctl and keeps sticky
//   event capture in serdes_csr_sticky.
// - Returns registered read data one cycle after the read is presented.
// Assumes all status inputs are synchronous to clk, and NUM_CH <= 4 so that
// the two-per-lane error fields fit in eight bits.
module serdes_csr
    import serdes_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_wait,
    input  logic              seq_tx_ready,
    input  logic              seq_rx_ready,
    input  logic [NUM_CH-1:0] cdr_on_data,
    input  logic [NUM_CH-1:0] cdr_on_ref,
    input  logic [NUM_CH-1:0] lane_sync_evt,
    input  logic [2*NUM_CH-1:0] lane_code_evt,
    input  logic [2*NUM_CH-1:0] lane_disp_evt,
    output logic [NUM_CH-1:0] tx_rst_pulse,
    output logic [NUM_CH-1:0] rx_rst_pulse,
    output logic [NUM_CH-1:0] tx_rst_hold,
    output logic [NUM_CH-1:0] rx_ana_rst_hold,
    output logic [NUM_CH-1:0] rx_rst_hold,
    output logic [NUM_CH-1:0] loopback_en,
    output logic [NUM_CH-1:0] cdr_ltd_req,
    output logic [NUM_CH-1:0] cdr_ltr_req,
    output logic              fast_sim
);

    localparam int ERR_W = 2 * NUM_CH;

    reg_sel_e          sel;
    logic              wr_stb;
    logic              rd_cap;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] loop_q;
    logic [NUM_CH-1:0] ltd_q;
    logic [NUM_CH-1:0] ltr_q;
    logic              sim_q;
    logic [2:0]        man_q;
    logic [NUM_CH-1:0] sync_q;
    logic [ERR_W-1:0]  code_q;
    logic [ERR_W-1:0]  disp_q;
    logic [DATA_W-1:0] rd_val;
    logic              wdata_unused;

    assign wdata_unused = &{1'b0, bus_wdata};

    serdes_csr_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .sel      (sel),
        .wr_stb   (wr_stb),
        .rd_cap   (rd_cap),
        .bus_wait (bus_wait)
    );

    // Channel mask: all channels enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '1;
        else if (wr_stb && sel == SEL_CHMASK) mask_q <= bus_wdata[NUM_CH-1:0];
    end

    // Loopback and lock-mode request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q <= '0;
            ltd_q  <= '0;
            ltr_q  <= '0;
        end else if (wr_stb) begin
            if (sel == SEL_LOOP)   loop_q <= bus_wdata[NUM_CH-1:0];
            if (sel == SEL_LTDREQ) ltd_q  <= bus_wdata[NUM_CH-1:0];
            if (sel == SEL_LTRREQ) ltr_q  <= bus_wdata[NUM_CH-1:0];
        end
    end

    // Simulation shortcut flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sim_q <= 1'b0;
        else if (wr_stb && sel == SEL_SIM) sim_q <= bus_wdata[0];
    end

    serdes_csr_rstctl #(.NUM_CH(NUM_CH)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask     (mask_q),
        .cmd_wr   (wr_stb && sel == SEL_RSTCMD),
        .cmd_data (bus_wdata[1:0]),
        .man_wr   (wr_stb && sel == SEL_RSTMAN),
        .man_data (bus_wdata[MAN_LSB +: MAN_W]),
        .man_q    (man_q),
        .tx_pulse (tx_rst_pulse),
        .rx_pulse (rx_rst_pulse),
        .tx_hold  (tx_rst_hold),
        .rxa_hold (rx_ana_rst_hold),
        .rxd_hold (rx_rst_hold)
    );

    serdes_csr_sticky #(.WIDTH(NUM_CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (lane_sync_evt),
        .clr   (rd_cap && sel == SEL_SYNC),
        .q     (sync_q)
    );

    // A disparity error also counts as a code error.
    serdes_csr_sticky #(.WIDTH(ERR_W)) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (lane_code_evt | lane_disp_evt),
        .clr   (rd_cap && sel == SEL_ERR),
        .q     (code_q)
    );

    serdes_csr_sticky #(.WIDTH(ERR_W)) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (lane_disp_evt),
        .clr   (rd_cap && sel == SEL_ERR),
        .q     (disp_q)
    );

    // Read multiplexer: unmapped words read as zero.
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_CHMASK: rd_val[NUM_CH-1:0] = mask_q;
            SEL_RSTCMD: begin
                rd_val[0] = seq_tx_ready;
                rd_val[1] = seq_rx_ready;
            end
            SEL_RSTMAN: rd_val[MAN_LSB +: MAN_W] = man_q;
            SEL_LOOP:   rd_val[NUM_CH-1:0] = loop_q;
            SEL_LTDREQ: rd_val[NUM_CH-1:0] = ltd_q;
            SEL_LTRREQ: rd_val[NUM_CH-1:0] = ltr_q;
            SEL_LTDST:  rd_val[NUM_CH-1:0] = cdr_on_data;
            SEL_LTRST:  rd_val[NUM_CH-1:0] = cdr_on_ref;
            SEL_SYNC:   rd_val[NUM_CH-1:0] = sync_q;
            SEL_ERR: begin
                rd_val[ERR_CODE_LSB +: ERR_W] = code_q;
                rd_val[ERR_W-1:0]             = disp_q;
            end
            SEL_SIM:    rd_val[0] = sim_q;
            default:    rd_val = '0;
        endcase
    end

    // Registered read data, loaded in the stalled first cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_cap) bus_rdata <= rd_val;
    end

    assign loopback_en = loop_q;
    assign cdr_ltd_req = ltd_q;
    assign cdr_ltr_req = ltr_q;
    assign fast_sim    = sim_q;

endmodule

// File: rtl/serdes_csr_chk.sv
// Checker for serdes_csr, attached with bind. It checks the read handshake
// shape, the causes of reset pulses, the stability of held resets, sticky
// capture and the simulation flag.
module serdes_csr_chk
    import serdes_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_wait,
    input logic [DATA_W-1:0] bus_rdata,
    input reg_sel_e          sel,
    input logic [NUM_CH-1:0] mask_q,
    input logic [NUM_CH-1:0] tx_rst_pulse,
    input logic [NUM_CH-1:0] rx_rst_pulse,
    input logic [NUM_CH-1:0] tx_rst_hold,
    input logic [NUM_CH-1:0] rx_ana_rst_hold,
    input logic [NUM_CH-1:0] rx_rst_hold,
    input logic [NUM_CH-1:0] sync_q,
    input logic [NUM_CH-1:0] lane_sync_evt,
    input logic [2*NUM_CH-1:0] code_q,
    input logic [2*NUM_CH-1:0] lane_disp_evt,
    input logic              fast_sim
);

    p_wait_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> !bus_wait);

    p_wait_needs_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> !bus_wait);

    p_tx_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rst_pulse != '0) |-> $past(bus_wr && bus_addr == A_RSTCMD && bus_wdata[0]));

    p_rx_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst_pulse != '0) |-> $past(bus_wr && bus_addr == A_RSTCMD && bus_wdata[1]));

    p_pulse_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rst_pulse | rx_rst_pulse) != '0) |->
            (((tx_rst_pulse | rx_rst_pulse) & ~$past(mask_q)) == '0));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_RSTMAN || bus_addr == A_CHMASK)) |=>
            $stable({tx_rst_hold, rx_ana_rst_hold, rx_rst_hold}));

    p_sync_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wait && bus_addr == A_SYNC) |=> ((sync_q & $past(sync_q)) == $past(sync_q)));

    p_sync_evt_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sync_evt != '0) |=>
            ((sync_q & $past(lane_sync_evt)) == $past(lane_sync_evt)));

    p_disp_marks_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_disp_evt != '0) |=>
            ((code_q & $past(lane_disp_evt)) == $past(lane_disp_evt)));

    p_sim_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_SIM) |=> $stable(fast_sim));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && sel == SEL_NONE) |=> (bus_rdata == '0));

endmodule

bind serdes_csr serdes_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_wait        (bus_wait),
    .bus_rdata       (bus_rdata),
    .sel             (sel),
    .mask_q          (mask_q),
    .tx_rst_pulse    (tx_rst_pulse),
    .rx_rst_pulse    (rx_rst_pulse),
    .tx_rst_hold     (tx_rst_hold),
    .rx_ana_rst_hold (rx_ana_rst_hold),
    .rx_rst_hold     (rx_rst_hold),
    .sync_q          (sync_q),
    .lane_sync_evt   (lane_sync_evt),
    .code_q          (code_q),
    .lane_disp_evt   (lane_disp_evt),
    .fast_sim        (fast_sim)
);

// File: tb/test_serdes_csr.sv
// Bench for serdes_csr. It sweeps masks, register patterns, lock inputs and
// every error bit position. Expected values come from the requirement text.
module test_serdes_csr;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_wait;
    logic        seq_tx_ready = 1'b0;
    logic        seq_rx_ready = 1'b0;
    logic [N-1:0]   cdr_on_data = '0;
    logic [N-1:0]   cdr_on_ref = '0;
    logic [N-1:0]   lane_sync_evt = '0;
    logic [2*N-1:0] lane_code_evt = '0;
    logic [2*N-1:0] lane_disp_evt = '0;
    logic [N-1:0] tx_rst_pulse, rx_rst_pulse, tx_rst_hold, rx_ana_rst_hold, rx_rst_hold;
    logic [N-1:0] loopback_en, cdr_ltd_req, cdr_ltr_req;
    logic         fast_sim;

    int errors = 0;
    int checks = 0;
    logic wait_first;
    logic wait_second;

    always #10 clk = ~clk;

    serdes_csr #(.NUM_CH(N)) i_serdes_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
        .seq_tx_ready(seq_tx_ready), .seq_rx_ready(seq_rx_ready),
        .cdr_on_data(cdr_on_data), .cdr_on_ref(cdr_on_ref),
        .lane_sync_evt(lane_sync_evt), .lane_code_evt(lane_code_evt),
        .lane_disp_evt(lane_disp_evt), .tx_rst_pulse(tx_rst_pulse),
        .rx_rst_pulse(rx_rst_pulse), .tx_rst_hold(tx_rst_hold),
        .rx_ana_rst_hold(rx_ana_rst_hold), .rx_rst_hold(rx_rst_hold),
        .loopback_en(loopback_en), .cdr_ltd_req(cdr_ltd_req),
        .cdr_ltr_req(cdr_ltr_req), .fast_sim(fast_sim)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read with an optional sync event driven in the clearing cycle.
    task automatic bus_read_evt(input logic [8:0] a, input logic [N-1:0] ev,
                                output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; lane_sync_evt = ev;
        #1 wait_first = bus_wait;
        @(negedge clk);
        lane_sync_evt = '0;
        wait_second = bus_wait;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        bus_read_evt(a, '0, d);
    endtask

    task automatic pulse_evt(input logic [N-1:0] s, input logic [2*N-1:0] c,
                             input logic [2*N-1:0] p);
        @(negedge clk);
        lane_sync_evt = s; lane_code_evt = c; lane_disp_evt = p;
        @(negedge clk);
        lane_sync_evt = '0; lane_code_evt = '0; lane_disp_evt = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2, R4, R5, R11, R1)
        check("R1 idle wait", {31'd0, bus_wait}, 32'd0);
        check("R3 pulses idle", {24'd0, tx_rst_pulse, rx_rst_pulse}, 32'd0);
        check("R4 holds reset", {20'd0, tx_rst_hold, rx_ana_rst_hold, rx_rst_hold}, 32'd0);
        check("R5 outputs reset", {20'd0, loopback_en, cdr_ltd_req, cdr_ltr_req}, 32'd0);
        check("R11 sim reset", {31'd0, fast_sim}, 32'd0);
        bus_read(9'h041, d);
        check("R2 mask reset", d, 32'h0000_000F);
        check("R1 wait first cycle", {31'd0, wait_first}, 32'd1);
        check("R1 wait second cycle", {31'd0, wait_second}, 32'd0);

        // R2/R3/R4: sweep every mask
        for (int m = 0; m < 16; m++) begin
            bus_write(9'h041, 32'hFFFF_FFF0 | m);
            bus_read(9'h041, d);
            check("R2 mask readback", d, m);
            bus_write(9'h042, 32'h3);
            check("R3 tx pulse", {28'd0, tx_rst_pulse}, m);
            check("R3 rx pulse", {28'd0, rx_rst_pulse}, m);
            @(negedge clk);
            check("R3 pulse one cycle", {24'd0, tx_rst_pulse, rx_rst_pulse}, 32'd0);
            bus_write(9'h042, 32'h2);
            check("R3 rx only", {24'd0, tx_rst_pulse, rx_rst_pulse}, {24'd0, 4'd0, 4'(m)});
            for (int v = 0; v < 8; v++) begin
                bus_write(9'h044, 32'hFFFF_FFF1 & ~32'hE | (v << 1));
                check("R4 tx hold", {28'd0, tx_rst_hold}, v[0] ? m : 0);
                check("R4 rx analog hold", {28'd0, rx_ana_rst_hold}, v[1] ? m : 0);
                check("R4 rx digital hold", {28'd0, rx_rst_hold}, v[2] ? m : 0);
                repeat (2) @(negedge clk);
                check("R4 hold persists", {28'd0, tx_rst_hold}, v[0] ? m : 0);
                bus_read(9'h044, d);
                check("R4 manual readback", d, v << 1);
            end
            bus_write(9'h044, 32'h0);
        end
        bus_write(9'h041, 32'hF);

        // R3: ready flags readback
        for (int r = 0; r < 4; r++) begin
            seq_tx_ready = r[0]; seq_rx_ready = r[1];
            bus_read(9'h042, d);
            check("R3 ready flags", d, r);
        end

        // R5: read-write channel registers
        for (int v = 0; v < 16; v++) begin
            bus_write(9'h061, 32'hFFFF_FFF0 | v);
            bus_write(9'h064, 32'hFFFF_FFF0 | (v ^ 5));
            bus_write(9'h065, 32'hFFFF_FFF0 | (v ^ 10));
            check("R5 loopback out", {28'd0, loopback_en}, v);
            check("R5 lock data out", {28'd0, cdr_ltd_req}, v ^ 5);
            check("R5 lock ref out", {28'd0, cdr_ltr_req}, v ^ 10);
            bus_read(9'h061, d); check("R5 loopback read", d, v);
            bus_read(9'h064, d); check("R5 lock data read", d, v ^ 5);
            bus_read(9'h065, d); check("R5 lock ref read", d, v ^ 10);
        end

        // R6: read-only lock status
        for (int v = 0; v < 16; v++) begin
            cdr_on_data = 4'(v); cdr_on_ref = ~4'(v);
            bus_write(9'h066, 32'h0);
            bus_write(9'h067, 32'h0);
            bus_read(9'h066, d); check("R6 locked data", d, v);
            bus_read(9'h067, d); check("R6 locked ref", d, (~v) & 4'hF);
        end

        // R7: sync capture per lane
        for (int l = 0; l < N; l++) begin
            pulse_evt(4'(1 << l), '0, '0);
            repeat (3) @(negedge clk);
            bus_read(9'h084, d); check("R7 sync captured", d, 1 << l);
            bus_read(9'h084, d); check("R7 sync cleared", d, 0);
        end
        pulse_evt(4'b0101, '0, '0);
        pulse_evt(4'b0010, '0, '0);
        bus_read(9'h084, d); check("R7 sync accumulate", d, 32'h7);

        // R8/R9: every error bit position
        for (int k = 0; k < 2 * N; k++) begin
            pulse_evt('0, 8'(1 << k), '0);
            bus_read(9'h085, d); check("R8 code field", d, 1 << (8 + k));
            bus_read(9'h085, d); check("R8 cleared", d, 0);
            pulse_evt('0, '0, 8'(1 << k));
            bus_read(9'h085, d); check("R9 disparity sets both", d, (1 << k) | (1 << (8 + k)));
            bus_read(9'h085, d); check("R8 both cleared", d, 0);
        end
        pulse_evt('0, 8'h81, 8'h10);
        pulse_evt('0, 8'h02, 8'h00);
        bus_read(9'h085, d); check("R8 sticky mix", d, 32'h0000_9310);

        // R10: event in the clearing cycle survives
        pulse_evt(4'b0001, '0, '0);
        bus_read_evt(9'h084, 4'b0100, d);
        check("R10 clearing read value", d, 32'h1);
        bus_read(9'h084, d);
        check("R10 event kept", d, 32'h4);

        // R11: simulation flag
        bus_write(9'h08a, 32'hFFFF_FFFF);
        check("R11 sim set", {31'd0, fast_sim}, 32'd1);
        bus_read(9'h08a, d); check("R11 sim read", d, 32'h1);
        bus_write(9'h08a, 32'h0);
        check("R11 sim clear", {31'd0, fast_sim}, 32'd0);

        // R12: unmapped addresses
        bus_write(9'h061, 32'h5);
        bus_write(9'h041, 32'h9);
        foreach (d[i]) begin end
        for (int j = 0; j < 10; j++) begin
            logic [8:0] ua;
            case (j)
                0: ua = 9'h000; 1: ua = 9'h040; 2: ua = 9'h043; 3: ua = 9'h045;
                4: ua = 9'h060; 5: ua = 9'h062; 6: ua = 9'h086; 7: ua = 9'h08b;
                8: ua = 9'h141; default: ua = 9'h1FF;
            endcase
            bus_write(ua, 32'hFFFF_FFFF);
            bus_read(ua, d);
            check("R12 unmapped read", d, 0);
            check("R12 outputs untouched",
                  {11'd0, fast_sim, loopback_en, cdr_ltd_req, cdr_ltr_req, tx_rst_hold},
                  {11'd0, 1'b0, 4'h5, 4'(15 ^ 5), 4'(15 ^ 10), 4'h0});
            check("R12 no pulse", {24'd0, tx_rst_pulse, rx_rst_pulse}, 32'd0);
        end
        bus_read(9'h041, d); check("R12 mask untouched", d, 32'h9);
        bus_read(9'h044, d); check("R12 manual untouched", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule